// File: doc/BRIEF.md
# Fragmented Message Receiver

This block drains a message from a slot-based circular buffer, one 32-bit slot at a time, and rebuilds it as a stream of bytes. A message may be split over several fragments. Each fragment opens with one header slot that gives a byte length and a "last fragment" flag. The payload slots follow the header. The caller starts a reception with a pulse on `start` and supplies the largest number of bytes it can accept. The block then reads fragments until one of three things happens: a fragment flagged as last arrives, a fragment of zero length arrives, or the space is used up. When an unfinished message has emptied the buffer, the block rings a doorbell so that the peer sends more.

The reception runs as a state machine. `S_IDLE` moves to `S_CLR` on start, or straight to `S_FIN` when the space is zero. `S_CLR` pulses the interrupt clear and moves to `S_WRDY`. `S_WRDY` waits for the peer to be ready, then moves to `S_WHDR`. `S_WHDR` waits for a filled slot, then moves to `S_RHDR`. `S_RHDR` reads the header and moves to `S_WBODY`. It moves to `S_FEND` instead for a zero length, and to `S_FIN` for an oversize length. `S_WBODY` waits until every payload slot is present, then moves to `S_RSLOT`. `S_RSLOT` pops one slot and moves to `S_EMIT`. `S_EMIT` sends out one byte per cycle and returns to `S_RSLOT`, or moves to `S_FEND` when the fragment is exhausted. `S_FEND` may ring the doorbell, then moves either to `S_WHDR` for another fragment or to `S_FIN`. `S_FIN` publishes the result and returns to `S_IDLE`. Each of the three waiting states gives up after `TMO` cycles and moves to `S_FIN` with a timeout error.

Top module: `frag_rx`

## Requirements
- R1: A start pulse with nonzero space produces exactly one `int_clr` pulse. The block then waits for `peer_rdy`. If `peer_rdy` stays low for `TMO` cycles, the block finishes with `err_tmo`=1 and `ok`=0 and reads no slot.
- R2: A header slot is read only once `fill_cnt` is at least 1. `slot_rd` is never high while `fill_cnt` is 0. If no slot appears within `TMO` cycles, the block finishes with `err_tmo`=1.
- R3: The header fields are placed as follows: destination address in bits 7:0, source address in bits 15:8, byte length in bits 24:16, and the last-fragment flag in bit 31.
- R4: When a fragment length exceeds the remaining space, the block finishes with `err_ovf`=1 and `ok`=0, and it emits no byte of that fragment.
- R5: Before reading any payload, the block waits until `fill_cnt` is at least ceil(length/4). If that count is not reached within `TMO` cycles, the block finishes with `err_tmo`=1 and emits no byte.
- R6: Bytes leave a slot least significant byte first, at one per cycle with `byte_valid` high. Only length mod 4 bytes of the final slot are kept when that value is nonzero; the padding bytes are dropped. `total_len` counts the emitted bytes.
- R7: Fragments that are not flagged as last are followed by further fragments, provided space remains. The output stream is their concatenation.
- R8: After a fragment that is not flagged as last, `doorbell` pulses for one cycle if `fill_cnt` is 0. If slots remain in the buffer, the doorbell does not pulse.
- R9: Reception ends once the remaining space reaches zero, even on a fragment that is not flagged as last. In that case `ok`=0 with no error flag set.
- R10: A zero-length fragment sets `zero_warn` and ends the reception. It sets no error flag, and `ok` then equals its last-fragment flag.
- R11: If `peer_rdy` is low in the finishing cycle, the block reports `ok`=0.
- R12: `done` is a one-cycle pulse. `ok`, the error flags, `zero_warn` and `total_len` hold their values until the next start. A start with `max_len`=0 finishes with `ok`=0 and reads no slot.
- R13: A single 6-byte last fragment that is already in the buffer, with `peer_rdy` high, raises `done` 16 clock edges after the edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a reception |
| max_len | input | LEN_W | Byte space available to the caller |
| peer_rdy | input | 1 | Peer ready indication |
| fill_cnt | input | CNT_W | Number of filled slots in the buffer |
| slot_data | input | 32 | Slot at the head of the buffer |
| slot_rd | output | 1 | Pop the head slot on this edge |
| int_clr | output | 1 | Clear interrupt status pulse |
| doorbell | output | 1 | Request more data from the peer |
| byte_valid | output | 1 | `byte_data` carries a payload byte |
| byte_data | output | 8 | Payload byte |
| total_len | output | LEN_W | Bytes received in this reception |
| done | output | 1 | Reception finished, one cycle |
| ok | output | 1 | Success: last-fragment flag seen, no error, peer ready |
| err_ovf | output | 1 | Fragment longer than the remaining space |
| err_tmo | output | 1 | A wait timed out |
| zero_warn | output | 1 | A zero-length fragment was seen |

## Verification
`slot_rd`, `int_clr`, `doorbell` and `byte_valid` are decoded from the state register, so each one is valid in the cycle after the edge that enters its state. `done` and the result flags are registered one edge after `S_FIN`. The 6-byte case therefore lands at edge 16, counted from the edge that samples `start`. The bench drives every input at the falling edge and samples every output at the falling edge. The model buffer pops its read pointer with a nonblocking update on the rising edge. Waits for `done` or the doorbell are bounded cycle counts, and the latency check counts the exact edge.

// File: rtl/frag_rx_pkg.sv
package frag_rx_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_CLR, S_WRDY, S_WHDR, S_RHDR,
        S_WBODY, S_RSLOT, S_EMIT, S_FEND, S_FIN
    } rx_state_t;

    localparam int SLOT_BYTES = 4;
    localparam int FLEN_W     = 9;
    localparam int FLEN_LSB   = 16;
    localparam int LAST_BIT   = 31;
endpackage

// File: rtl/frag_rx_hdr.sv
module frag_rx_hdr
    import frag_rx_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [FLEN_W-1:0] flen,
    input  logic [LEN_W-1:0]  space,
    output logic              too_big,
    output logic              is_zero,
    output logic [7:0]        nslots
);
    localparam int PAD = LEN_W - FLEN_W;

    always_comb begin
        too_big = {{PAD{1'b0}}, flen} > space;
        is_zero = (flen == '0);
        nslots  = 8'((10'(flen) + 10'(SLOT_BYTES - 1)) >> 2);
    end
endmodule

// File: rtl/frag_rx_timer.sv
module frag_rx_timer #(
    parameter int TMO = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);
    localparam int CW = $clog2(TMO + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == CW'(TMO - 1));
endmodule

// File: rtl/frag_rx_unpack.sv
module frag_rx_unpack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] din,
    input  logic [2:0]  nbytes,
    input  logic        adv,
    output logic [7:0]  dout,
    output logic        last
);
    logic [31:0] sh;
    logic [2:0]  cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (load) begin
            sh  <= din;
            cnt <= nbytes;
        end else if (adv) begin
            sh  <= {8'h00, sh[31:8]};
            cnt <= cnt - 3'd1;
        end
    end

    assign dout = sh[7:0];
    assign last = (cnt == 3'd1);
endmodule

// File: rtl/frag_rx.sv
module frag_rx
    import frag_rx_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CNT_W = 8,
    parameter int TMO   = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] max_len,
    input  logic             peer_rdy,
    input  logic [CNT_W-1:0] fill_cnt,
    input  logic [31:0]      slot_data,
    output logic             slot_rd,
    output logic             int_clr,
    output logic             doorbell,
    output logic             byte_valid,
    output logic [7:0]       byte_data,
    output logic [LEN_W-1:0] total_len,
    output logic             done,
    output logic             ok,
    output logic             err_ovf,
    output logic             err_tmo,
    output logic             zero_warn
);
    rx_state_t st, st_n;

    logic [LEN_W-1:0]  left_q, max_q, total_q;
    logic [FLEN_W-1:0] frem_q;
    logic [7:0]        slots_q, h_slots;
    logic              last_q, got_q;
    logic              ovf_q, tmo_q, zw_q, ok_q, done_q;
    logic              h_big, h_zero, tmo_hit, u_last;
    logic [FLEN_W-1:0] h_len;
    logic              h_last;
    logic [2:0]        load_n;

    assign h_len  = slot_data[FLEN_LSB +: FLEN_W];
    assign h_last = slot_data[LAST_BIT];
    assign load_n = (frem_q >= FLEN_W'(SLOT_BYTES)) ? 3'd4 : frem_q[2:0];

    frag_rx_hdr #(.LEN_W(LEN_W)) u_hdr (
        .flen(h_len), .space(left_q),
        .too_big(h_big), .is_zero(h_zero), .nslots(h_slots)
    );

    frag_rx_timer #(.TMO(TMO)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .clr(st != st_n), .expired(tmo_hit)
    );

    frag_rx_unpack u_unp (
        .clk(clk), .rst_n(rst_n),
        .load(st == S_RSLOT), .din(slot_data), .nbytes(load_n),
        .adv(st == S_EMIT), .dout(byte_data), .last(u_last)
    );

    // next-state decision
    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE:  if (start) st_n = (max_len == '0) ? S_FIN : S_CLR;
            S_CLR:   st_n = S_WRDY;
            S_WRDY:  if (peer_rdy) st_n = S_WHDR;
                     else if (tmo_hit) st_n = S_FIN;
            S_WHDR:  if (fill_cnt != '0) st_n = S_RHDR;
                     else if (tmo_hit) st_n = S_FIN;
            S_RHDR:  if (h_big) st_n = S_FIN;
                     else if (h_zero) st_n = S_FEND;
                     else st_n = S_WBODY;
            S_WBODY: if (int'(fill_cnt) >= int'(slots_q)) st_n = S_RSLOT;
                     else if (tmo_hit) st_n = S_FIN;
            S_RSLOT: st_n = S_EMIT;
            S_EMIT:  if (u_last) st_n = (frem_q == FLEN_W'(1)) ? S_FEND : S_RSLOT;
            S_FEND:  st_n = (last_q || !got_q || left_q == '0) ? S_FIN : S_WHDR;
            S_FIN:   st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;
            left_q <= '0; max_q <= '0; total_q <= '0; frem_q <= '0;
            slots_q <= '0; last_q <= 1'b0; got_q <= 1'b0;
            ovf_q <= 1'b0; tmo_q <= 1'b0; zw_q <= 1'b0;
            ok_q <= 1'b0; done_q <= 1'b0;
        end else begin
            st     <= st_n;
            done_q <= (st == S_FIN);
            unique case (st)
                S_IDLE: if (start) begin
                    left_q <= max_len; max_q <= max_len; total_q <= '0;
                    last_q <= 1'b0; got_q <= 1'b0;
                    ovf_q <= 1'b0; tmo_q <= 1'b0; zw_q <= 1'b0; ok_q <= 1'b0;
                end
                S_WRDY:  if (!peer_rdy && tmo_hit) tmo_q <= 1'b1;
                S_WHDR:  if (fill_cnt == '0 && tmo_hit) tmo_q <= 1'b1;
                S_WBODY: if (int'(fill_cnt) < int'(slots_q) && tmo_hit) tmo_q <= 1'b1;
                S_RHDR: begin
                    last_q  <= h_last;
                    frem_q  <= h_len;
                    slots_q <= h_slots;
                    got_q   <= !h_zero;
                    if (h_big) ovf_q <= 1'b1;
                    else if (h_zero) zw_q <= 1'b1;
                end
                S_EMIT: begin
                    left_q  <= left_q - 1'b1;
                    total_q <= total_q + 1'b1;
                    frem_q  <= frem_q - 1'b1;
                end
                S_FIN: ok_q <= last_q && peer_rdy && !ovf_q && !tmo_q;
                default: ;
            endcase
        end
    end

    // state-decoded outputs
    always_comb begin
        slot_rd    = (st == S_RHDR) || (st == S_RSLOT);
        int_clr    = (st == S_CLR);
        byte_valid = (st == S_EMIT);
        doorbell   = (st == S_FEND) && !last_q && (fill_cnt == '0);
        total_len  = total_q;
        done       = done_q;
        ok         = ok_q;
        err_ovf    = ovf_q;
        err_tmo    = tmo_q;
        zero_warn  = zw_q;
    end

    // R2: never pop an empty buffer
    a_r2_no_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        slot_rd |-> fill_cnt != '0);
    // R4: byte count bounded by the caller's space
    a_r4_within_max: assert property (@(posedge clk) disable iff (!rst_n)
        total_q <= max_q);
    // R6: a byte is only emitted while space remains
    a_r6_byte_budget: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> left_q != '0);
    // R8: a doorbell is never followed by a byte in the next cycle
    a_r8_bell_then_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell |=> !byte_valid);
    // R12: an error result is never reported as success
    a_r12_err_not_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (err_ovf || err_tmo)) |-> !ok);
    // R12: done lasts a single cycle
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/sim_frag_rx.sv
module sim_frag_rx;
    localparam int LEN_W = 16;
    localparam int CNT_W = 8;
    localparam int TMO   = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LEN_W-1:0] max_len = '0;
    logic peer_rdy = 1'b1;
    logic [CNT_W-1:0] fill_cnt;
    logic [31:0] slot_data;
    logic slot_rd, int_clr, doorbell, byte_valid, done, ok, err_ovf, err_tmo, zero_warn;
    logic [7:0] byte_data;
    logic [LEN_W-1:0] total_len;

    always #2 clk = ~clk;

    frag_rx #(.LEN_W(LEN_W), .CNT_W(CNT_W), .TMO(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .max_len(max_len),
        .peer_rdy(peer_rdy), .fill_cnt(fill_cnt), .slot_data(slot_data),
        .slot_rd(slot_rd), .int_clr(int_clr), .doorbell(doorbell),
        .byte_valid(byte_valid), .byte_data(byte_data), .total_len(total_len),
        .done(done), .ok(ok), .err_ovf(err_ovf), .err_tmo(err_tmo),
        .zero_warn(zero_warn)
    );

    // model buffer
    logic [31:0] mem [0:255];
    int wr_ptr = 0;
    int rd_ptr = 0;
    assign fill_cnt  = CNT_W'(wr_ptr - rd_ptr);
    assign slot_data = mem[rd_ptr % 256];
    always @(posedge clk) begin
        if (!rst_n) rd_ptr <= wr_ptr;
        else if (slot_rd) rd_ptr <= rd_ptr + 1;
    end

    // monitors
    logic [7:0] rxb [0:1023];
    int nrx = 0, nbell = 0, nclr = 0, nrd = 0;
    always @(negedge clk) begin
        if (byte_valid) begin rxb[nrx % 1024] = byte_data; nrx++; end
        if (doorbell) nbell++;
        if (int_clr) nclr++;
        if (slot_rd) nrd++;
    end

    logic [7:0] expb [0:1023];
    int nexp, b_rx, b_bell, b_clr, b_rd, lat;
    int nchk = 0, nfail = 0, cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL R12 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input bit c, input string r, input int a, input int e);
        nchk++;
        if (!c) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", r, a, e);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic mark();
        nexp = 0; b_rx = nrx; b_bell = nbell; b_clr = nclr; b_rd = nrd;
    endtask

    task automatic push(input logic [31:0] w);
        mem[wr_ptr % 256] = w;
        wr_ptr++;
    endtask

    task automatic push_frag(input int len, input bit lst, input int base);
        logic [31:0] w;
        push({lst, 6'd0, 9'(len), 8'hA5, 8'h3C});
        for (int s = 0; s < (len + 3) / 4; s++) begin
            for (int b = 0; b < 4; b++) begin
                w[b*8 +: 8] = 8'(base + s*4 + b);
                if (s*4 + b < len) begin expb[nexp] = 8'(base + s*4 + b); nexp++; end
            end
            push(w);
        end
    endtask

    task automatic run(input int mx);
        lat = -1;
        max_len = LEN_W'(mx);
        start = 1'b1;
        for (int k = 1; k <= 400; k++) begin
            @(posedge clk); @(negedge clk);
            start = 1'b0;
            if (done) begin lat = k; break; end
        end
        chk(lat > 0, "R12 done seen", lat, 1);
    endtask

    task automatic chk_bytes(input string r);
        int bad = 0;
        chk(nrx - b_rx == nexp, {r, " byte count"}, nrx - b_rx, nexp);
        for (int i = 0; i < nexp && i < nrx - b_rx; i++)
            if (rxb[(b_rx + i) % 1024] != expb[i]) bad++;
        chk(bad == 0, {r, " byte values"}, bad, 0);
    endtask

    task automatic t_reset();
        chk(!done && !ok && !slot_rd && !byte_valid && !int_clr && total_len == 0,
            "R12 reset state", {done, ok, slot_rd, byte_valid}, 0);
    endtask

    task automatic t_single();
        mark(); push_frag(6, 1'b1, 8'h10);
        run(64);
        chk(lat == 16, "R13 latency", lat, 16);
        chk_bytes("R6 R3 single");
        chk(total_len == 6 && ok && !err_ovf && !err_tmo, "R6 total/ok", total_len, 6);
        chk(nclr - b_clr == 1, "R1 int_clr pulses", nclr - b_clr, 1);
        chk(nbell == b_bell, "R8 no bell on last", nbell - b_bell, 0);
        @(negedge clk);
        chk(!done && ok && total_len == 6, "R12 hold", {done, ok}, 1);
    endtask

    task automatic t_two_frag();
        mark(); push_frag(8, 1'b0, 8'h40); push_frag(3, 1'b1, 8'h80);
        run(64);
        chk_bytes("R7 two fragments");
        chk(total_len == 11 && ok, "R7 total", total_len, 11);
        chk(nbell == b_bell, "R8 bell while slots remain", nbell - b_bell, 0);
    endtask

    task automatic t_doorbell();
        mark(); push_frag(5, 1'b0, 8'h20);
        fork
            run(64);
            begin
                for (int k = 0; k < 200; k++) begin
                    @(negedge clk);
                    if (nbell > b_bell) break;
                end
                push_frag(4, 1'b1, 8'h60);
            end
        join
        chk(nbell - b_bell == 1, "R8 doorbell once", nbell - b_bell, 1);
        chk_bytes("R7 after doorbell");
        chk(total_len == 9 && ok, "R8 total", total_len, 9);
    endtask

    task automatic t_overflow();
        mark(); push_frag(6, 1'b1, 8'h00); nexp = 0;
        run(4);
        chk(err_ovf && !ok && !err_tmo, "R4 overflow flags", {err_ovf, ok}, 2);
        chk(nrx == b_rx && total_len == 0, "R4 no bytes", nrx - b_rx, 0);
        do_reset();
    endtask

    task automatic t_space_end();
        mark(); push_frag(8, 1'b0, 8'h90);
        run(8);
        chk_bytes("R9 exact space");
        chk(!ok && !err_ovf && !err_tmo && total_len == 8, "R9 ends not ok", ok, 0);
    endtask

    task automatic t_zero();
        mark(); push_frag(0, 1'b1, 0);
        run(16);
        chk(zero_warn && ok && !err_ovf && !err_tmo, "R10 zero last", {zero_warn, ok}, 3);
        chk(total_len == 0 && nrx == b_rx, "R10 no bytes", total_len, 0);
        mark(); push_frag(0, 1'b0, 0);
        run(16);
        chk(zero_warn && !ok && !err_tmo && !err_ovf, "R10 zero not last", ok, 0);
    endtask

    task automatic t_rdy_drop();
        mark(); push_frag(4, 1'b1, 8'hC0);
        fork
            run(16);
            begin
                for (int k = 0; k < 100; k++) begin
                    @(negedge clk);
                    if (byte_valid) break;
                end
                peer_rdy = 1'b0;
            end
        join
        chk(!ok && !err_tmo && total_len == 4, "R11 not ready at end", ok, 0);
        peer_rdy = 1'b1;
    endtask

    task automatic t_rdy_tmo();
        mark(); peer_rdy = 1'b0; push_frag(0, 1'b1, 0);
        run(16);
        chk(err_tmo && !ok, "R1 ready timeout", err_tmo, 1);
        chk(nrd == b_rd && fill_cnt == 1, "R1 no slot read", nrd - b_rd, 0);
        peer_rdy = 1'b1;
        do_reset();
    endtask

    task automatic t_hdr_tmo();
        mark();
        run(16);
        chk(err_tmo && !ok && nrd == b_rd, "R2 header timeout", err_tmo, 1);
    endtask

    task automatic t_body_tmo();
        mark();
        push({1'b1, 6'd0, 9'd8, 8'h01, 8'h02}); push(32'h0403_0201);
        run(32);
        chk(err_tmo && !ok, "R5 body timeout", err_tmo, 1);
        chk(nrx == b_rx && nrd - b_rd == 1, "R5 no payload read", nrd - b_rd, 1);
        do_reset();
    endtask

    task automatic t_zero_max();
        mark(); push_frag(4, 1'b1, 0);
        run(0);
        chk(!ok && nrd == b_rd && nclr == b_clr, "R12 zero space", nrd - b_rd, 0);
        do_reset();
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        t_reset();
        t_single();
        t_two_frag();
        t_doorbell();
        t_overflow();
        t_space_end();
        t_zero();
        t_rdy_drop();
        t_rdy_tmo();
        t_hdr_tmo();
        t_body_tmo();
        t_zero_max();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule